// File: doc/BRIEF.md
# Decoded Integer Execute Unit

This unit executes a small set of 32-bit register-format and immediate-format integer instructions. Each cycle it may accept one instruction word together with the values of its two source registers. It decodes the major opcode and, for register-format words, the function code. It forms the operand and computes the result. It then presents that result with the destination register number and a write-enable. Register reads, fetch, memory access and control flow all belong to neighbouring blocks.

The immediate operand is sign-extended for the two add forms and zero-extended for the logical forms. The upper-immediate form places the 16-bit field in the top half of the word. The three shifts take their count from the 5-bit shift field of the word, not from a register. An encoding outside the supported set raises an unsupported flag and blocks the write. A destination of register 0 also blocks the write, so that register keeps the value zero. All outputs come from one register stage.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is held and after it is released, before any instruction is accepted, out_valid, wr_en, unsupported, result and dest_idx are all zero.
- R2: Opcode bits [31:26] = 0x00 with function bits [5:0] = 0x00 gives result = rt_val shifted left by the shift field bits [10:6], with zeros filled in from the right. The destination is the rd field, bits [15:11].
- R3: Opcode 0x00 with function 0x02 gives result = rt_val shifted right by bits [10:6], with zeros filled in from the left. The destination is rd.
- R4: Opcode 0x00 with function 0x03 gives result = rt_val shifted right by bits [10:6], with copies of bit 31 filled in from the left. The destination is rd.
- R5: Opcodes 0x08 and 0x09 both give rs_val plus the sign-extended immediate, bits [15:0], modulo 2^32. The destination is the rt field, bits [20:16].
- R6: Opcode 0x0c gives rs_val AND the zero-extended immediate. Opcode 0x0d gives rs_val OR the zero-extended immediate. The destination is rt.
- R7: Opcode 0x0f gives the immediate in bits [31:16] and zeros in bits [15:0], whatever the value of rs_val. The destination is rt. An upper-immediate of 0xdead, followed by an OR-immediate of 0xbeef on that result, yields 0xdeadbeef.
- R8: Any other opcode, or opcode 0x00 with a function code other than 0x00, 0x02 or 0x03, sets unsupported to 1 and wr_en to 0, with result 0 and dest_idx 0.
- R9: A supported instruction whose destination index is 0 gives wr_en = 0 and unsupported = 0. The result is still computed.
- R10: An instruction accepted with in_valid at a rising clock edge appears on the outputs at that same edge, with out_valid = 1. A clock edge with in_valid = 0 gives out_valid = 0, wr_en = 0 and unsupported = 0, and leaves result and dest_idx unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| out_valid | output | 1 | Outputs hold an executed instruction |
| result | output | 32 | Computed result |
| wr_en | output | 1 | Result is to be written to dest_idx |
| dest_idx | output | 5 | Destination register number |
| unsupported | output | 1 | The accepted word is not in the supported set |

## Verification
Every result is due one clock edge after its word is presented. The bench drives each word on a falling edge, and the following rising edge captures it into the output stage. The bench samples the outputs on the next falling edge, half a period after that capture, and compares them with values it computes itself from the word and operands. After an idle edge with in_valid low, it checks the cleared flags and the held payload in the same way. After reset release, it waits for the two-flop release synchronizer before it presents the first word.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG       = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADD_IMM_A = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADD_IMM_B = 6'h09;
  localparam logic [OPC_W-1:0] OPC_AND_IMM   = 6'h0c;
  localparam logic [OPC_W-1:0] OPC_OR_IMM    = 6'h0d;
  localparam logic [OPC_W-1:0] OPC_UPPER_IMM = 6'h0f;

  localparam logic [FN_W-1:0] FN_SHL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SHRL = 6'h02;
  localparam logic [FN_W-1:0] FN_SHRA = 6'h03;

  typedef enum logic [2:0] {
    ALU_SHL,
    ALU_SHRL,
    ALU_SHRA,
    ALU_ADD,
    ALU_AND,
    ALU_OR,
    ALU_UPPER,
    ALU_NONE
  } alu_op_e;

  typedef struct packed {
    alu_op_e          alu;
    logic             sext;
    logic             upper;
    logic [IDX_W-1:0] dest;
    logic             legal;
  } dec_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output dec_t             dec
);

  always_comb begin
    dec.alu   = ALU_NONE;
    dec.sext  = 1'b0;
    dec.upper = 1'b0;
    dec.dest  = '0;
    dec.legal = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_SHL: begin
            dec.alu   = ALU_SHL;
            dec.dest  = rd_idx;
            dec.legal = 1'b1;
          end
          FN_SHRL: begin
            dec.alu   = ALU_SHRL;
            dec.dest  = rd_idx;
            dec.legal = 1'b1;
          end
          FN_SHRA: begin
            dec.alu   = ALU_SHRA;
            dec.dest  = rd_idx;
            dec.legal = 1'b1;
          end
          default: ;
        endcase
      end
      OPC_ADD_IMM_A, OPC_ADD_IMM_B: begin
        dec.alu   = ALU_ADD;
        dec.sext  = 1'b1;
        dec.dest  = rt_idx;
        dec.legal = 1'b1;
      end
      OPC_AND_IMM: begin
        dec.alu   = ALU_AND;
        dec.dest  = rt_idx;
        dec.legal = 1'b1;
      end
      OPC_OR_IMM: begin
        dec.alu   = ALU_OR;
        dec.dest  = rt_idx;
        dec.legal = 1'b1;
      end
      OPC_UPPER_IMM: begin
        dec.alu   = ALU_UPPER;
        dec.upper = 1'b1;
        dec.dest  = rt_idx;
        dec.legal = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exu_operand.sv
module exu_operand
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sext,
  input  logic              upper,
  output logic [DATA_W-1:0] imm_ext
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic              fill_bit;
  logic [DATA_W-1:0] low_form;
  logic [DATA_W-1:0] high_form;

  assign fill_bit  = sext & imm[IMM_W-1];
  assign low_form  = {{PAD_W{fill_bit}}, imm};
  assign high_form = {{(PAD_W - IMM_W){1'b0}}, imm, {IMM_W{1'b0}}};
  assign imm_ext   = upper ? high_form : low_form;

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);

  logic [W-1:0] pre;
  logic [W-1:0] post;
  logic         fill;
  logic [W-1:0] stg [AW+1];

  // Left shifts reuse the right-shift network on a bit-reversed word.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign pre[i]  = left ? din[W-1-i]  : din[i];
    assign dout[i] = left ? post[W-1-i] : post[i];
  end

  assign fill   = arith & ~left & din[W-1];
  assign stg[0] = pre;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int STEP = 2 ** s;
    assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
  end

  assign post = stg[AW];

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] imm_ext,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] shifted;
  logic              is_left;
  logic              is_arith;

  assign is_left  = (op == ALU_SHL);
  assign is_arith = (op == ALU_SHRA);

  exu_shift #(
    .W  (DATA_W),
    .AW (SH_W)
  ) shift_i (
    .din   (src_b),
    .amt   (shamt),
    .left  (is_left),
    .arith (is_arith),
    .dout  (shifted)
  );

  always_comb begin
    unique case (op)
      ALU_SHL, ALU_SHRL, ALU_SHRA: res = shifted;
      ALU_ADD:                     res = src_a + imm_ext;
      ALU_AND:                     res = src_a & imm_ext;
      ALU_OR:                      res = src_a | imm_ext;
      ALU_UPPER:                   res = imm_ext;
      default:                     res = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [4:0]        dest_idx,
  output logic              unsupported
);

  localparam int SH_W = $clog2(DATA_W);

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [OPC_W-1:0] f_opc;
  logic [IDX_W-1:0] f_rt;
  logic [IDX_W-1:0] f_rd;
  logic [SH_W-1:0]  f_sh;
  logic [FN_W-1:0]  f_fn;
  logic [IMM_W-1:0] f_imm;
  logic [4:0]       unused_rs_field;

  assign f_opc           = instr[31:26];
  assign unused_rs_field = instr[25:21];
  assign f_rt            = instr[20:16];
  assign f_rd            = instr[15:11];
  assign f_sh            = instr[6 +: SH_W];
  assign f_fn            = instr[5:0];
  assign f_imm           = instr[15:0];

  dec_t              dec;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] alu_res;

  exu_decode dec_i (
    .opcode (f_opc),
    .funct  (f_fn),
    .rt_idx (f_rt),
    .rd_idx (f_rd),
    .dec    (dec)
  );

  exu_operand #(.DATA_W(DATA_W)) opnd_i (
    .imm     (f_imm),
    .sext    (dec.sext),
    .upper   (dec.upper),
    .imm_ext (imm_ext)
  );

  exu_alu #(.DATA_W(DATA_W), .SH_W(SH_W)) alu_i (
    .op      (dec.alu),
    .src_a   (rs_val),
    .src_b   (rt_val),
    .imm_ext (imm_ext),
    .shamt   (f_sh),
    .res     (alu_res)
  );

  logic              vld_d,  vld_q;
  logic              we_d,   we_q;
  logic              uns_d,  uns_q;
  logic [DATA_W-1:0] res_d,  res_q;
  logic [IDX_W-1:0]  dst_d,  dst_q;
  logic              pay_en;

  always_comb begin
    pay_en = in_valid;
    vld_d  = in_valid;
    we_d   = in_valid & dec.legal & (dec.dest != '0);
    uns_d  = in_valid & ~dec.legal;
    res_d  = dec.legal ? alu_res : '0;
    dst_d  = dec.legal ? dec.dest : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      we_q  <= 1'b0;
      uns_q <= 1'b0;
      res_q <= '0;
      dst_q <= '0;
    end else begin
      vld_q <= vld_d;
      we_q  <= we_d;
      uns_q <= uns_d;
      if (pay_en) begin
        res_q <= res_d;
        dst_q <= dst_d;
      end
    end
  end

  assign out_valid   = vld_q;
  assign wr_en       = we_q;
  assign unsupported = uns_q;
  assign result      = res_q;
  assign dest_idx    = dst_q;

endmodule

// File: rtl/exu_checker.sv
module exu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [5:0]  opc,
  input logic [4:0]  sh,
  input logic [5:0]  fn,
  input logic [15:0] imm,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        wr_en,
  input logic [4:0]  dest_idx,
  input logic        unsupported
);

  p_shl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc == 6'h00 && fn == 6'h00) |=>
      (result == ($past(rt_val) << $past(sh))));

  p_shra_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc == 6'h00 && fn == 6'h03) |=>
      (result == 32'($signed($past(rt_val)) >>> $past(sh))));

  p_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opc == 6'h08 || opc == 6'h09)) |=>
      (result == $past(rs_val) + {{16{$past(imm[15])}}, $past(imm)}));

  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc == 6'h0f) |=>
      (result == {$past(imm), 16'h0000}));

  p_unsup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (!wr_en && result == 32'h0 && dest_idx == 5'd0));

  p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dest_idx == 5'd0) |-> !wr_en);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !unsupported &&
                   $stable(result) && $stable(dest_idx)));

endmodule

bind int_exec_unit exu_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .opc         (instr[31:26]),
  .sh          (instr[10:6]),
  .fn          (instr[5:0]),
  .imm         (instr[15:0]),
  .rs_val      (rs_val),
  .rt_val      (rt_val),
  .out_valid   (out_valid),
  .result      (result),
  .wr_en       (wr_en),
  .dest_idx    (dest_idx),
  .unsupported (unsupported)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic        out_valid;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  dest_idx;
  logic        unsupported;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  int_exec_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .out_valid   (out_valid),
    .result      (result),
    .wr_en       (wr_en),
    .dest_idx    (dest_idx),
    .unsupported (unsupported)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic we, output logic [4:0] d,
                       output logic un, output string tag);
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [15:0] im;
    op = w[31:26]; fn = w[5:0]; sh = w[10:6]; im = w[15:0];
    un = 1'b0; r = 32'h0; d = 5'd0; tag = "R8";
    if (op == 6'h00 && fn == 6'h00) begin
      r = b << sh; d = w[15:11]; tag = "R2";
    end else if (op == 6'h00 && fn == 6'h02) begin
      r = b >> sh; d = w[15:11]; tag = "R3";
    end else if (op == 6'h00 && fn == 6'h03) begin
      r = 32'($signed(b) >>> sh); d = w[15:11]; tag = "R4";
    end else if (op == 6'h08 || op == 6'h09) begin
      r = a + {{16{im[15]}}, im}; d = w[20:16]; tag = "R5";
    end else if (op == 6'h0c) begin
      r = a & {16'h0, im}; d = w[20:16]; tag = "R6";
    end else if (op == 6'h0d) begin
      r = a | {16'h0, im}; d = w[20:16]; tag = "R6";
    end else if (op == 6'h0f) begin
      r = {im, 16'h0}; d = w[20:16]; tag = "R7";
    end else begin
      un = 1'b1;
    end
    we = !un && (d != 5'd0);
    if (!un && d == 5'd0) tag = "R9";
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ewe,
                       input logic [4:0] ed, input logic eun, input logic evld);
    n_vec++;
    if (out_valid !== evld || result !== er || wr_en !== ewe ||
        dest_idx !== ed || unsupported !== eun) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b res=%h we=%0b dst=%0d uns=%0b, expected vld=%0b res=%h we=%0b dst=%0d uns=%0b",
               tag, out_valid, result, wr_en, dest_idx, unsupported,
               evld, er, ewe, ed, eun);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic        ewe;
    logic [4:0]  ed;
    logic        eun;
    string       tag;
    model(w, a, b, er, ewe, ed, eun, tag);
    @(negedge clk);
    in_valid = 1'b1; instr = w; rs_val = a; rt_val = b;
    @(negedge clk);
    check(tag, er, ewe, ed, eun, 1'b1);
  endtask

  // R10: idle edge clears flags and holds the payload.
  task automatic idle_check();
    logic [31:0] r0;
    logic [4:0]  d0;
    r0 = result; d0 = dest_idx;
    in_valid = 1'b0;
    instr    = ~instr;
    rs_val   = ~rs_val;
    @(negedge clk);
    check("R10", r0, 1'b0, d0, 1'b0, 1'b0);
  endtask

  logic [31:0] pats [4];

  initial begin
    pats[0] = 32'h0000_0005;
    pats[1] = 32'h8000_0001;
    pats[2] = 32'hdead_beef;
    pats[3] = 32'h7fff_ffff;
    rst_n = 1'b0; in_valid = 1'b1; instr = 32'h0000_0840;
    rs_val = 32'h1234_5678; rt_val = 32'hffff_ffff;
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 1'b0, 5'd0, 1'b0, 1'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 1'b0, 5'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 1'b0, 5'd0, 1'b0, 1'b0);

    // R2 R3 R4: every shift count over several data patterns.
    foreach (pats[p]) begin
      for (int s = 0; s < 32; s++) begin
        apply({6'h00, 5'd3, 5'd4, 5'd8, 5'(s), 6'h00}, 32'h0, pats[p]);
        apply({6'h00, 5'd3, 5'd4, 5'd9, 5'(s), 6'h02}, 32'h0, pats[p]);
        apply({6'h00, 5'd3, 5'd4, 5'd10, 5'(s), 6'h03}, 32'h0, pats[p]);
      end
    end

    // R2: shift left by 6 equals times 64.
    apply({6'h00, 5'd0, 5'd4, 5'd8, 5'd6, 6'h00}, 32'h0, 32'd4);
    if (result !== 32'd256) begin
      n_fail++;
      $display("FAIL R2: shift by 6 got %h expected %h", result, 32'd256);
    end
    n_vec++;

    // R5 R6 R7: immediate forms over a spread of immediates and sources.
    for (int k = 0; k < 40; k++) begin
      logic [15:0] im;
      logic [31:0] a;
      im = 16'(k * 16'h1f3d) ^ ((k % 2 == 1) ? 16'h8000 : 16'h0);
      a  = 32'(k) * 32'h9e37_79b9;
      apply({6'h08, 5'd1, 5'(k % 31 + 1), im}, a, 32'h0);
      apply({6'h09, 5'd1, 5'(k % 31 + 1), im}, a, 32'h0);
      apply({6'h0c, 5'd1, 5'(k % 31 + 1), im}, a, 32'h0);
      apply({6'h0d, 5'd1, 5'(k % 31 + 1), im}, a, 32'h0);
      apply({6'h0f, 5'd1, 5'(k % 31 + 1), im}, a, 32'hffff_ffff);
    end
    // R5 boundary: wrap around and negative immediate.
    apply({6'h09, 5'd2, 5'd5, 16'hffff}, 32'h0000_0000, 32'h0);
    apply({6'h08, 5'd2, 5'd5, 16'h0001}, 32'hffff_ffff, 32'h0);

    // R7: upper then OR gives the full constant.
    apply({6'h0f, 5'd0, 5'd5, 16'hdead}, 32'h5555_5555, 32'h0);
    begin
      logic [31:0] hi;
      hi = result;
      apply({6'h0d, 5'd5, 5'd5, 16'hbeef}, hi, 32'h0);
      n_vec++;
      if (result !== 32'hdeadbeef) begin
        n_fail++;
        $display("FAIL R7: combined constant got %h expected %h", result, 32'hdeadbeef);
      end
    end

    // R8: every opcode, then every function code under opcode zero.
    for (int op = 0; op < 64; op++)
      apply({6'(op), 5'd7, 5'd12, 5'd13, 5'd2, 6'h2a}, 32'h0f0f_0f0f, 32'hf0f0_f0f0);
    for (int fn = 0; fn < 64; fn++)
      apply({6'h00, 5'd7, 5'd12, 5'd13, 5'd5, 6'(fn)}, 32'h0f0f_0f0f, 32'hf0f0_f0f0);

    // R9: destination zero in both formats.
    apply({6'h00, 5'd1, 5'd2, 5'd0, 5'd1, 6'h00}, 32'h0, 32'h3);
    apply({6'h09, 5'd1, 5'd0, 16'h0010}, 32'h20, 32'h0);
    apply({6'h0f, 5'd1, 5'd0, 16'h0010}, 32'h20, 32'h0);

    // R10: idle edges after a result and after an unsupported word.
    apply({6'h0d, 5'd1, 5'd9, 16'h00f0}, 32'h0000_0f00, 32'h0);
    idle_check();
    idle_check();
    apply({6'h3f, 26'h0}, 32'h0, 32'h0);
    idle_check();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule